// File: doc/BRIEF.md
# Memory Parity Check Policy Unit

This unit sits beside a memory port on a 20-bit physical address bus with 16-bit data words. On every access it decides which kind of checking applies: error correction, plain parity, or none. It bases the decision on the quadrant of the address space being accessed, on whether the access is an instruction fetch or an operand fetch, and on a 16-bit control register. It always produces the check bit to store with the write data. On reads in parity mode it compares the stored check bit with the recomputed one and raises an error flag one cycle later.

The first failure is logged. A failure is either a parity mismatch or a corrected-bit report from an external correction engine. The log records the low 16 bits of the failing physical address and a one-hot mask of the failing bit position. The log keeps that value until it is cleared, so later failures cannot overwrite it. Syndrome decoding and correction are done outside the block. Only the bit position that the external engine reports is taken in here.

Top module: `pcu_parity_policy`

## Requirements
- R1: After reset the control register holds 16'h00C6. Its field layout is: bits [3:0] are the quadrant enables (bit q enables quadrant q), bit 4 selects odd parity, bit 5 enables correction on instruction fetches, bit 6 enables correction on operand fetches, and bit 7 enables parity. A control write takes effect on the cycle after the write.
- R2: The quadrant is given by address bits [19:18]. When a quadrant's enable bit is 0, accesses to it have no correction, no parity, and no check enable, so a parity mismatch there raises no error.
- R3: In an enabled quadrant, `ecc_sel` is 1 when the matching correction enable is set: bit 5 for a fetch (`acc_fetch`=1), bit 6 for an operand access.
- R4: Correction takes precedence. `par_sel` is 1 only when the quadrant is enabled, bit 7 is set, and both bit 5 and bit 6 are clear. `chk_en` is `ecc_sel` OR `par_sel`.
- R5: `gen_parity` is the XOR of the 16 bits of `acc_wdata`, inverted when bit 4 is 1.
- R6: `par_err` is 1 in the cycle after a valid read (`acc_write`=0) with `par_sel`=1 whose `rd_check` differs from the parity of `rd_data` computed as in R5. It is 0 otherwise, including for writes.
- R7: When no failure is logged, a parity error loads `fail_valid`=1, `fail_addr`=acc_addr[15:0] and `fail_data`=0, because the bit position is unknown. The registers update at the same edge as `par_err`.
- R8: A valid read with `ecc_sel`=1 and `corr_valid`=1 is a failure. It logs `fail_data` as a one-hot mask with bit `corr_pos` set, along with the address as in R7. `corr_valid` has no effect when `ecc_sel` is 0.
- R9: While `fail_valid` is 1 and `fail_clr` is 0, later failures leave `fail_valid`, `fail_addr` and `fail_data` unchanged.
- R10: `fail_clr` zeroes the log at the next edge and wins over a failure in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write value |
| acc_valid | input | 1 | Access valid this cycle |
| acc_addr | input | 20 | Physical address |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 16 | Write data for check-bit generation |
| rd_data | input | 16 | Read data word |
| rd_check | input | 1 | Stored check bit of the read word |
| corr_valid | input | 1 | External engine corrected a bit on this read |
| corr_pos | input | 4 | Position of the corrected bit |
| fail_clr | input | 1 | Clear the failure log |
| chk_en | output | 1 | Some checking applies to this access |
| ecc_sel | output | 1 | Correction applies |
| par_sel | output | 1 | Parity checking applies |
| gen_parity | output | 1 | Check bit for acc_wdata |
| par_err | output | 1 | Parity error, registered |
| fail_valid | output | 1 | Failure log holds an entry |
| fail_addr | output | 16 | Low 16 address bits of the first failure |
| fail_data | output | 16 | One-hot mask of the failing bit |

## Verification
The decision outputs are tried under the reset control word, a parity-only word, an odd-parity word, a fetch-only correction word and a single-quadrant word. This separates quadrant masking, fetch-type selection and the suppression of parity by correction. Parity is checked with matching and mismatching stored bits under both polarities, and with a bad check bit on a write, to tell a read check apart from a write. The failure log is exercised with a first failure, a second failure that must not overwrite it, a clear that coincides with a failure, and a correction report that arrives when correction is off.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int ADDR_W    = 20;
    localparam int DATA_W    = 16;
    localparam int LOG_W     = 16;
    localparam int QSEL_W    = 2;
    localparam int N_QUAD    = 1 << QSEL_W;
    localparam int POS_W     = $clog2(DATA_W);
    localparam logic [15:0] CTRL_RESET = 16'h00C6;

    typedef struct packed {
        logic [7:0]        spare;
        logic              par_on;
        logic              ecc_data;
        logic              ecc_fetch;
        logic              odd;
        logic [N_QUAD-1:0] quad_on;
    } ctrl_t;

    typedef struct packed {
        logic ecc;
        logic par;
        logic odd;
    } policy_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic [DATA_W-1:0] onehot_of(input logic [POS_W-1:0] p);
        logic [DATA_W-1:0] m;
        m = '0;
        m[p] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pcu_ctrl_reg.sv
module pcu_ctrl_reg
    import pcu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [15:0] wdata,
    output ctrl_t       ctrl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= ctrl_t'(CTRL_RESET);
        else if (we)
            ctrl <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/pcu_policy.sv
module pcu_policy
    import pcu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  ctrl_t          ctrl,
    input  logic [AW-1:0]  addr,
    input  logic           fetch,
    output policy_t        pol
);
    localparam int QTOP = AW - 1;
    localparam int QLOW = AW - QSEL_W;

    logic [N_QUAD-1:0] hit;

    for (genvar q = 0; q < N_QUAD; q++) begin : g_quad
        assign hit[q] = (addr[QTOP:QLOW] == QSEL_W'(q)) && ctrl.quad_on[q];
    end

    logic region_on;
    logic ecc_any;
    assign region_on = |hit;
    assign ecc_any   = ctrl.ecc_fetch | ctrl.ecc_data;

    always_comb begin
        pol.odd = ctrl.odd;
        pol.ecc = region_on && (fetch ? ctrl.ecc_fetch : ctrl.ecc_data);
        pol.par = region_on && ctrl.par_on && !ecc_any;
    end
endmodule

// File: rtl/pcu_fail_log.sv
module pcu_fail_log
    import pcu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LOG_W,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          par_fail,
    input  logic          corr_fail,
    input  logic [LW-1:0] addr_low,
    input  logic [PW-1:0] pos,
    output logic          err_q,
    output logic          valid_q,
    output logic [LW-1:0] addr_q,
    output logic [DW-1:0] mask_q
);
    logic load;
    assign load = (par_fail || corr_fail) && !valid_q && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= 1'b0;
            valid_q <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
        end else begin
            err_q <= par_fail;
            if (clr) begin
                valid_q <= 1'b0;
                addr_q  <= '0;
                mask_q  <= '0;
            end else if (load) begin
                valid_q <= 1'b1;
                addr_q  <= addr_low;
                mask_q  <= corr_fail ? onehot_of(pos) : '0;
            end
        end
    end
endmodule

// File: rtl/pcu_parity_policy.sv
module pcu_parity_policy
    import pcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_fetch,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_check,
    input  logic              corr_valid,
    input  logic [POS_W-1:0]  corr_pos,
    input  logic              fail_clr,
    output logic              chk_en,
    output logic              ecc_sel,
    output logic              par_sel,
    output logic              gen_parity,
    output logic              par_err,
    output logic              fail_valid,
    output logic [LOG_W-1:0]  fail_addr,
    output logic [DATA_W-1:0] fail_data
);
    ctrl_t   ctrl;
    policy_t pol;
    logic    rd_ok;
    logic    par_fail;
    logic    corr_fail;

    pcu_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .ctrl  (ctrl)
    );

    pcu_policy #(.AW(ADDR_W)) u_pol (
        .ctrl  (ctrl),
        .addr  (acc_addr),
        .fetch (acc_fetch),
        .pol   (pol)
    );

    assign rd_ok     = acc_valid && !acc_write;
    assign par_fail  = rd_ok && pol.par && (parity_of(rd_data, pol.odd) != rd_check);
    assign corr_fail = rd_ok && pol.ecc && corr_valid;

    pcu_fail_log #(.DW(DATA_W), .LW(LOG_W), .PW(POS_W)) u_log (
        .clk       (clk),
        .rst       (rst),
        .clr       (fail_clr),
        .par_fail  (par_fail),
        .corr_fail (corr_fail),
        .addr_low  (acc_addr[LOG_W-1:0]),
        .pos       (corr_pos),
        .err_q     (par_err),
        .valid_q   (fail_valid),
        .addr_q    (fail_addr),
        .mask_q    (fail_data)
    );

    assign ecc_sel    = pol.ecc;
    assign par_sel    = pol.par;
    assign chk_en     = pol.ecc | pol.par;
    assign gen_parity = parity_of(acc_wdata, pol.odd);
endmodule

module pcu_parity_policy_chk
    import pcu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              fail_clr,
    input logic              ecc_sel,
    input logic              par_sel,
    input logic              par_err,
    input logic              fail_valid,
    input logic [LOG_W-1:0]  fail_addr,
    input logic [DATA_W-1:0] fail_data
);
    // R4: correction and parity never both selected
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ecc_sel && par_sel));

    // R6: an error follows only a valid parity-mode read
    a_r6_err_on_read: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !(par_sel && !acc_write) |=> !par_err);

    // R7: a fresh log entry carries the failing address
    a_r7_addr_logged: assert property (@(posedge clk) disable iff (rst)
        !fail_valid && !fail_clr && acc_valid && !acc_write && par_sel && !ecc_sel ##1 $rose(fail_valid)
        |-> fail_addr == $past(acc_addr[LOG_W-1:0]));

    // R9: a held entry stays put
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        fail_valid && !fail_clr |=> fail_valid && $stable(fail_addr) && $stable(fail_data));

    // R10: clear empties the log
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        fail_clr |=> !fail_valid && fail_addr == '0 && fail_data == '0);

    // R8: the mask holds at most one set bit
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fail_data));
endmodule

bind pcu_parity_policy pcu_parity_policy_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .fail_clr   (fail_clr),
    .ecc_sel    (ecc_sel),
    .par_sel    (par_sel),
    .par_err    (par_err),
    .fail_valid (fail_valid),
    .fail_addr  (fail_addr),
    .fail_data  (fail_data)
);

// File: tb/pcu_parity_policy_tb_top.sv
`timescale 1ns/1ps
module pcu_parity_policy_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_fetch = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] rd_data = '0;
    logic        rd_check = 1'b0;
    logic        corr_valid = 1'b0;
    logic [3:0]  corr_pos = '0;
    logic        fail_clr = 1'b0;
    logic        chk_en, ecc_sel, par_sel, gen_parity, par_err, fail_valid;
    logic [15:0] fail_addr, fail_data;

    always #2 clk = ~clk;

    pcu_parity_policy dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // staged stimulus
    logic        s_we = 0, s_valid = 0, s_fetch = 0, s_write = 0, s_rchk = 0, s_cv = 0, s_clr = 0;
    logic [15:0] s_ctrl = 0, s_wdata = 0, s_rdata = 0;
    logic [19:0] s_addr = 0;
    logic [3:0]  s_pos = 0;

    // model state
    logic [15:0] m_ctrl = 16'h00C6;
    logic        m_fv = 0;
    logic [15:0] m_fa = 0, m_fd = 0;

    typedef struct {
        logic        perr;
        logic        fv;
        logic [15:0] fa;
        logic [15:0] fd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_stage();
        s_we = 0; s_valid = 0; s_fetch = 0; s_write = 0; s_rchk = 0;
        s_cv = 0; s_clr = 0; s_wdata = 0; s_rdata = 0; s_pos = 0;
    endtask

    task automatic step(input string tag);
        logic qen, eany, e, p, g, perr, cf;
        exp_t it;
        @(negedge clk);
        ctrl_we = s_we; ctrl_wdata = s_ctrl; acc_valid = s_valid; acc_addr = s_addr;
        acc_fetch = s_fetch; acc_write = s_write; acc_wdata = s_wdata; rd_data = s_rdata;
        rd_check = s_rchk; corr_valid = s_cv; corr_pos = s_pos; fail_clr = s_clr;
        #1;
        qen  = m_ctrl[s_addr[19:18]];
        eany = m_ctrl[5] | m_ctrl[6];
        e    = qen && (s_fetch ? m_ctrl[5] : m_ctrl[6]);
        p    = qen && m_ctrl[7] && !eany;
        g    = (^s_wdata) ^ m_ctrl[4];
        chk(tag, "ecc_sel", 32'(ecc_sel), 32'(e));
        chk(tag, "par_sel", 32'(par_sel), 32'(p));
        chk(tag, "chk_en", 32'(chk_en), 32'(e | p));
        chk(tag, "gen_parity", 32'(gen_parity), 32'(g));
        perr = s_valid && !s_write && p && (((^s_rdata) ^ m_ctrl[4]) != s_rchk);
        cf   = s_valid && !s_write && e && s_cv;
        if (s_clr) begin
            m_fv = 0; m_fa = 0; m_fd = 0;
        end else if (!m_fv && (perr || cf)) begin
            m_fv = 1; m_fa = s_addr[15:0];
            m_fd = cf ? (16'h1 << s_pos) : 16'h0;
        end
        if (s_we) m_ctrl = s_ctrl;
        it.perr = perr; it.fv = m_fv; it.fa = m_fa; it.fd = m_fd; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            chk(it.tag, "par_err", 32'(par_err), 32'(it.perr));
            chk(it.tag, "fail_valid", 32'(fail_valid), 32'(it.fv));
            chk(it.tag, "fail_addr", 32'(fail_addr), 32'(it.fa));
            chk(it.tag, "fail_data", 32'(fail_data), 32'(it.fd));
        end
    end

    task automatic rd(input string tag, input logic [19:0] a, input logic f,
                      input logic [15:0] d, input logic c);
        idle_stage();
        s_valid = 1; s_addr = a; s_fetch = f; s_rdata = d; s_rchk = c;
        step(tag);
    endtask

    task automatic wctrl(input string tag, input logic [15:0] v);
        idle_stage();
        s_we = 1; s_ctrl = v;
        step(tag);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state of the log
        chk("R1", "reset par_err", 32'(par_err), 0);
        chk("R1", "reset fail_valid", 32'(fail_valid), 0);
        chk("R1", "reset fail_addr", 32'(fail_addr), 0);

        // R1/R3 default word: quadrant 1 operand read gets correction
        rd("R3", 20'h4_0010, 0, 16'h0001, 0);
        // R2: quadrant 0 off by default
        rd("R2", 20'h0_0020, 0, 16'h0001, 0);
        // R4: fetch in quadrant 1: parity suppressed by operand correction enable
        rd("R4", 20'h5_0000, 1, 16'h0001, 0);

        // R8: correction report logged as one-hot
        idle_stage(); s_valid = 1; s_addr = 20'h8_1234; s_cv = 1; s_pos = 4'd5; step("R8");
        // R9: a second report does not overwrite
        idle_stage(); s_valid = 1; s_addr = 20'h8_5678; s_cv = 1; s_pos = 4'd9; step("R9");
        // R10: clear
        idle_stage(); s_clr = 1; step("R10");

        // R1: write takes effect next cycle
        wctrl("R1", 16'h008F);
        rd("R1", 20'h0_0000, 0, 16'h0003, 0);

        // R5: generation under even parity
        idle_stage(); s_write = 1; s_valid = 1; s_addr = 20'h1_0000; s_wdata = 16'h8001; step("R5");
        idle_stage(); s_write = 1; s_valid = 1; s_addr = 20'h1_0000; s_wdata = 16'h0700; step("R5");

        // R6: good read, bad read
        rd("R6", 20'hC_0042, 0, 16'h0003, 0);
        rd("R7", 20'hC_ABCD, 0, 16'h0003, 1);
        // R9: later parity failure keeps first entry
        rd("R9", 20'h4_1111, 1, 16'h0007, 0);
        // R6: write with mismatching check bit raises nothing
        idle_stage(); s_valid = 1; s_write = 1; s_addr = 20'h4_2222; s_rdata = 16'h0001; s_rchk = 0; step("R6");
        // R6: invalid cycle raises nothing
        idle_stage(); s_addr = 20'h4_2222; s_rdata = 16'h0001; s_rchk = 0; step("R6");

        // R10: clear wins over same-cycle failure
        idle_stage(); s_clr = 1; s_valid = 1; s_addr = 20'h0_3333; s_rdata = 16'h0001; s_rchk = 0; step("R10");
        idle_stage(); step("R10");

        // R5/R6 odd parity
        wctrl("R5", 16'h009F);
        rd("R5", 20'h2_0000, 0, 16'h0003, 1);
        idle_stage(); s_write = 1; s_valid = 1; s_wdata = 16'h00FF; step("R5");
        rd("R6", 20'h2_0456, 0, 16'h0003, 0);
        idle_stage(); s_clr = 1; step("R10");

        // R3/R4: fetch-only correction, parity bit also set
        wctrl("R3", 16'h00AF);
        rd("R3", 20'h3_0000, 1, 16'h0001, 0);
        rd("R4", 20'h3_0000, 0, 16'h0001, 0);
        // R8: report on non-correction access ignored
        idle_stage(); s_valid = 1; s_addr = 20'h3_0101; s_cv = 1; s_pos = 4'd3; step("R8");
        idle_stage(); step("R8");
        // R8: report on fetch logs bit 15
        idle_stage(); s_valid = 1; s_fetch = 1; s_addr = 20'hF_FFFF; s_cv = 1; s_pos = 4'd15; step("R8");
        idle_stage(); s_clr = 1; step("R10");

        // R2: only quadrant 3 enabled for parity
        wctrl("R2", 16'h0088);
        rd("R2", 20'h0_0777, 0, 16'h0001, 0);
        rd("R2", 20'h7_0777, 0, 16'h0001, 0);
        rd("R2", 20'hF_0777, 0, 16'h0001, 0);
        idle_stage(); step("R2");
        idle_stage(); step("R2");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule